// File: doc/BRIEF.md
# Multiprocessor Miscellaneous Control Register

This block holds one 64-bit control and status word that up to four processors share. Inside the word are a per-processor interprocessor-interrupt flag, a per-processor interval-timer flag and two four-bit arbitration fields. Each field follows its own write rule: write-one-to-clear, write-one-to-set, set-only-while-empty, or a set requested through a separate strobe field. One bit of the write data works as an override that empties both arbitration fields. A nibble of plain read/write bits completes the word.

Software writes the whole word in one cycle by pulsing the write strobe with 64 bits of data. A read is combinational. The requesting processor's two-bit number is merged into the low two bits of the value returned. Each processor has a timer-set pulse input that raises its timer flag. The stored interprocessor flags and timer flags drive the interrupt lines directly, so a write takes effect on those lines in the cycle after the strobe.

Top module: `mp_misc_ctl`

## Requirements
- R1: A synchronous active-high reset clears the stored word to zero. Both interrupt line groups are then low, and a read returns only the requester number in bits [1:0].
- R2: During a write, every data bit set to 1 at positions [11:4] or 28 clears the stored bit at that position. Timer flags sit at [7:4] and interprocessor flags at [11:8], with lane i at bit 4+i and bit 8+i.
- R3: During a write, data bit 12+i set to 1 sets interprocessor flag i (bit 8+i). This set is applied after the clears, so a flag that is cleared and requested in the same write ends up set.
- R4: When write data bit 20 is 1, stored bits [23:16] become zero, and neither arbitration set rule acts on that write.
- R5: When write data bit 20 is 0, each data bit at 1 in [23:20] sets the matching stored bit. Bit 20 itself therefore cannot be set.
- R6: When write data bit 20 is 0, data bits [19:16] are ORed into the stored [19:16] only if that stored field is zero. Otherwise the field keeps its value.
- R7: During a write, stored bits [43:40] are replaced by data bits [43:40].
- R8: The read data equals the stored word ORed with the two-bit requester number in bits [1:0].
- R9: Interprocessor line i equals stored bit 8+i and timer line i equals stored bit 4+i. Both change in the cycle after the write or pulse that caused the change.
- R10: A timer-set pulse on lane i sets stored bit 4+i. If a clearing write hits the same bit in the same cycle, the pulse wins.
- R11: Stored bits outside [11:4], [23:16], 28 and [43:40] always read as zero. Bit 28 can only be cleared, so it also stays zero.
- R12: In a cycle with no write and no timer pulse, the stored word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | 64 | Write data word |
| rd_cpu | input | 2 | Number of the processor issuing the read |
| rd_data | output | 64 | Stored word ORed with the requester number |
| tmr_set | input | NCPU | Per-processor timer-set pulses |
| ipi_irq | output | NCPU | Interprocessor interrupt lines |
| tmr_irq | output | NCPU | Timer interrupt lines |

## Verification
A wrong stored bit appears at the ports no later than the cycle after the write or pulse that produced it. A flag error shows on an interrupt line, and an arbitration or read/write field error shows in the read data. The bench compares both interrupt groups and the full read word after every cycle against a model, so a corrupted word is reported at the first sample after it forms. The set-only-while-empty rule and the clear-versus-pulse race only show up for particular sequences, so directed runs produce them on purpose. Without those runs, a flaw there would stay hidden until the stored field happened to be non-empty.

// File: rtl/mp_misc_pkg.sv
package mp_misc_pkg;
    localparam int REG_W      = 64;
    localparam int LANES      = 4;
    localparam int ID_W       = 2;
    localparam int ITI_LO     = 4;
    localparam int IPI_LO     = 8;
    localparam int REQ_LO     = 12;
    localparam int WIN_LO     = 16;
    localparam int TRY_LO     = 20;
    localparam int ARB_CLR    = 20;
    localparam int ARB_HI     = 23;
    localparam int SPARE_W1C  = 28;
    localparam int RW_LO      = 40;
    localparam int RW_W       = 4;

    // Bits that software may clear by writing a one.
    function automatic logic [REG_W-1:0] w1c_mask(input int ncpu);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < ncpu; i++) begin
            m[ITI_LO + i] = 1'b1;
            m[IPI_LO + i] = 1'b1;
        end
        m[SPARE_W1C] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/mp_misc_wr.sv
module mp_misc_wr
    import mp_misc_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] cur,
    output logic [REG_W-1:0] nxt
);
    localparam logic [REG_W-1:0] CLR_MASK = w1c_mask(NCPU);

    logic [REG_W-1:0] stage_clr;
    logic [REG_W-1:0] stage_arb;
    logic [REG_W-1:0] stage_req;
    logic             unused_wd;

    assign unused_wd = ^{wr_data[3:0], wr_data[REG_W-1:RW_LO+RW_W], wr_data[39:24]};

    always_comb begin
        stage_clr = cur & ~(wr_data & CLR_MASK);
        stage_arb = stage_clr;
        if (wr_data[ARB_CLR]) begin
            stage_arb[ARB_HI:WIN_LO] = '0;
        end else begin
            stage_arb[TRY_LO +: NCPU] = stage_clr[TRY_LO +: NCPU] | wr_data[TRY_LO +: NCPU];
            if (stage_clr[WIN_LO +: NCPU] == '0) begin
                stage_arb[WIN_LO +: NCPU] = wr_data[WIN_LO +: NCPU];
            end
        end
        stage_req = stage_arb;
        stage_req[IPI_LO +: NCPU] = stage_arb[IPI_LO +: NCPU] | wr_data[REQ_LO +: NCPU];
        stage_req[RW_LO +: RW_W]  = wr_data[RW_LO +: RW_W];
        nxt = wr_en ? stage_req : cur;
    end
endmodule

// File: rtl/mp_misc_tmr.sv
module mp_misc_tmr
    import mp_misc_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic [REG_W-1:0] after_wr,
    input  logic [NCPU-1:0]  tmr_set,
    output logic [REG_W-1:0] nxt
);
    always_comb begin
        nxt = after_wr;
        for (int i = 0; i < NCPU; i++) begin
            if (tmr_set[i]) nxt[ITI_LO + i] = 1'b1;
        end
    end
endmodule

// File: rtl/mp_misc_rd.sv
module mp_misc_rd
    import mp_misc_pkg::*;
(
    input  logic [REG_W-1:0] stored,
    input  logic [ID_W-1:0]  rd_cpu,
    output logic [REG_W-1:0] rd_data
);
    assign rd_data = stored | {{(REG_W-ID_W){1'b0}}, rd_cpu};
endmodule

// File: rtl/mp_misc_ctl.sv
module mp_misc_ctl
    import mp_misc_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [ID_W-1:0]  rd_cpu,
    output logic [REG_W-1:0] rd_data,
    input  logic [NCPU-1:0]  tmr_set,
    output logic [NCPU-1:0]  ipi_irq,
    output logic [NCPU-1:0]  tmr_irq
);
    logic [REG_W-1:0] word_q;
    logic [REG_W-1:0] word_wr;
    logic [REG_W-1:0] word_d;

    mp_misc_wr #(.NCPU(NCPU)) u_wr (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cur     (word_q),
        .nxt     (word_wr)
    );

    mp_misc_tmr #(.NCPU(NCPU)) u_tmr (
        .after_wr (word_wr),
        .tmr_set  (tmr_set),
        .nxt      (word_d)
    );

    mp_misc_rd u_rd (
        .stored  (word_q),
        .rd_cpu  (rd_cpu),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    always_comb begin
        ipi_irq = word_q[IPI_LO +: NCPU];
        tmr_irq = word_q[ITI_LO +: NCPU];
    end
endmodule

// File: rtl/mp_misc_ctl_chk.sv
module mp_misc_ctl_chk
    import mp_misc_pkg::*;
#(
    parameter int NCPU = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic [NCPU-1:0]  tmr_set,
    input logic [NCPU-1:0]  ipi_irq,
    input logic [NCPU-1:0]  tmr_irq
);
    localparam logic [REG_W-1:0] LIVE = 64'h0000_0F00_10FF_0FF3;

    AST_TMR_PULSE_WINS: assert property (@(posedge clk) disable iff (rst)
        (tmr_set != '0) |=> ((tmr_irq & $past(tmr_set)) == $past(tmr_set))); // R10

    AST_TMR_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((tmr_irq & $past(~tmr_irq & ~tmr_set)) == '0)); // R10

    AST_IPI_REQ_SETS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((ipi_irq & $past(wr_data[REQ_LO +: NCPU])) == $past(wr_data[REQ_LO +: NCPU]))); // R3

    AST_IPI_W1C: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((ipi_irq & $past(wr_data[IPI_LO +: NCPU] & ~wr_data[REQ_LO +: NCPU])) == '0)); // R2

    AST_ARB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[ARB_CLR]) |=> (rd_data[ARB_HI:WIN_LO] == '0)); // R4

    AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((rd_data & ~LIVE) == '0)); // R11

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && tmr_set == '0) |=> ($stable(ipi_irq) && $stable(tmr_irq))); // R12
endmodule

bind mp_misc_ctl mp_misc_ctl_chk #(.NCPU(NCPU)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .tmr_set (tmr_set),
    .ipi_irq (ipi_irq),
    .tmr_irq (tmr_irq)
);

// File: tb/sim_mp_misc_ctl.sv
`timescale 1ns/1ps
module sim_mp_misc_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_cpu = 2'd0;
    logic [63:0] rd_data;
    logic [3:0]  tmr_set = '0;
    logic [3:0]  ipi_irq;
    logic [3:0]  tmr_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] exp_word = '0;

    always #5 clk = ~clk;

    mp_misc_ctl #(.NCPU(4)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_cpu(rd_cpu), .rd_data(rd_data), .tmr_set(tmr_set),
        .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
    );

    function automatic logic [63:0] model(input logic [63:0] old, input logic w,
                                          input logic [63:0] d, input logic [3:0] ts);
        logic [63:0] n;
        n = old;
        if (w) begin
            for (int i = 0; i < 4; i++) begin
                if (d[4+i]) n[4+i] = 1'b0;
                if (d[8+i]) n[8+i] = 1'b0;
            end
            if (d[28]) n[28] = 1'b0;
            if (d[20]) n[23:16] = 4'h0 << 0;
            else begin
                n[23:20] = n[23:20] | d[23:20];
                if (n[19:16] == 4'h0) n[19:16] = d[19:16];
            end
            n[11:8]  = n[11:8] | d[15:12];
            n[43:40] = d[43:40];
        end
        for (int i = 0; i < 4; i++) if (ts[i]) n[4+i] = 1'b1;
        return n;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // One cycle of stimulus, then compare every output against the model.
    task automatic step(input logic w, input logic [63:0] d, input logic [3:0] ts);
        @(negedge clk);
        wr_en = w; wr_data = d; tmr_set = ts;
        exp_word = model(exp_word, w, d, ts);
        @(posedge clk);
        #2;
        wr_en = 1'b0; tmr_set = '0;
        check("R8 read word", rd_data, exp_word | {62'd0, rd_cpu});
        check("R9 ipi lines", {60'd0, ipi_irq}, {60'd0, exp_word[11:8]});
        check("R9 timer lines", {60'd0, tmr_irq}, {60'd0, exp_word[7:4]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rd_cpu = 2'd3;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset read", rd_data, 64'd3);
        check("R1 reset lines", {56'd0, ipi_irq, tmr_irq}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        rd_cpu = 2'd0;

        // R10: pulse sets, pulse beats same-cycle clear
        step(1'b0, 64'd0, 4'b0001);
        check("R10 pulse sets", {60'd0, tmr_irq}, 64'd1);
        step(1'b1, 64'h10, 4'b0001);
        check("R10 pulse wins", {60'd0, tmr_irq}, 64'd1);
        step(1'b1, 64'h10, 4'b0000);
        check("R2 timer clear", {60'd0, tmr_irq}, 64'd0);

        // R3: clear and request together ends set
        step(1'b1, 64'h1100, 4'b0000);
        check("R3 request after clear", {60'd0, ipi_irq}, 64'd1);
        step(1'b1, 64'h0100, 4'b0000);
        check("R2 ipi clear", {60'd0, ipi_irq}, 64'd0);

        // Arbitration fields
        step(1'b1, 64'h0010_0000, 4'b0000);
        check("R4 arb cleared", {56'd0, rd_data[23:16]}, 64'd0);
        step(1'b1, 64'h0002_0000, 4'b0000);
        check("R6 set when empty", {60'd0, rd_data[19:16]}, 64'd2);
        step(1'b1, 64'h0005_0000, 4'b0000);
        check("R6 held when nonempty", {60'd0, rd_data[19:16]}, 64'd2);
        step(1'b1, 64'h00E0_0000, 4'b0000);
        check("R5 w1s upper", {60'd0, rd_data[23:20]}, 64'hE);
        step(1'b1, 64'h001F_0000, 4'b0000);
        check("R4 override no set", {56'd0, rd_data[23:16]}, 64'd0);

        // R7 plain field
        step(1'b1, 64'h0000_0A00_0000_0000, 4'b0000);
        check("R7 rw field", {60'd0, rd_data[43:40]}, 64'hA);
        step(1'b1, 64'd0, 4'b0000);
        check("R7 rw replaced", {60'd0, rd_data[43:40]}, 64'd0);

        // R11 all ones
        step(1'b1, '1, 4'b0000);
        check("R11 dead bits", rd_data & ~64'h0000_0F00_10FF_0FF3, 64'd0);

        // R12 idle holds
        step(1'b0, '1, 4'b0000);
        check("R12 hold", rd_data, exp_word);

        // R8 requester number
        for (int c = 0; c < 4; c++) begin
            rd_cpu = c[1:0];
            #1;
            check("R8 id merge", rd_data, exp_word | 64'(c));
        end

        // Random traffic
        for (int k = 0; k < 600; k++) begin
            logic [63:0] d;
            logic        w;
            logic [3:0]  ts;
            d  = {$urandom, $urandom};
            w  = ($urandom % 10) < 7;
            ts = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            rd_cpu = 2'($urandom);
            step(w, d, ts);
        end
        finish_run();
    end
endmodule